// File: doc/BRIEF.md
# Address Translation Result Register

This unit turns a single register write into an address translation query and keeps the formatted answer. The write supplies a virtual address and a small operation selector. The unit captures both and presents one request to an external table walker through a valid/ready pair. It then waits, with its response ready raised, for the walker's answer. The answer is either a physical frame number, with a flag for a 16 MB mapping, or a fault with a 6-bit status code.

The answer is packed into a 64-bit result register, which is read as a low word and a high word. A static mode input selects one of two layouts. The long layout spans 64 bits and always carries a marker bit. The short layout fits in 32 bits, with the high word held at zero. While a query is outstanding the unit raises `busy`, and any further command write is dropped.

Top module: `xlat_par_unit`

## Requirements
- R1: A command write while idle produces exactly one walker request, held with `wk_req_valid` high and with `wk_req_vaddr` and `wk_req_op` stable until `wk_req_ready` is seen. `wk_req_valid` falls in the cycle after that handshake.
- R2: `wk_req_user` equals bit 1 of the accepted operation selector (1 = unprivileged, 0 = privileged).
- R3: `busy` rises in the cycle after a command is accepted and falls in the cycle after the response handshake. `wk_rsp_ready` is high only after the request handshake and before the response.
- R4: A command write while `busy` is high is ignored: no new request, no change to the outstanding request payload, and no change to the result.
- R5: The result register resets to zero. It changes only in the cycle after a response handshake and otherwise holds its value.
- R6: Long layout, success: bits [39:12] carry the returned physical bits [39:12] and bit 11 is 1. Every other bit is 0, and the 16 MB flag has no effect.
- R7: Long layout, fault: bit 0 is 1, bits [6:1] carry the 6-bit status and bit 11 is 1. Every other bit is 0, so no write-not-read indication appears.
- R8: Short layout, success without the 16 MB flag: bits [31:12] carry physical bits [31:12]. Every other bit, including the whole high word, is 0.
- R9: Short layout, success with the 16 MB flag: bits [31:24] carry physical bits [31:24] and bit 1 is 1. Every other bit, including the whole high word, is 0.
- R10: Short layout, fault: bit 0 is 1 and bits [4:1] carry status bits [3:0]. Status bits [5:4] are dropped, and every other bit, including the high word, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_mode | input | 1 | Static layout select: 1 = long, 0 = short |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 3 | Operation selector; bit 1 = unprivileged |
| cmd_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | Query outstanding |
| wk_req_valid | output | 1 | Request to walker valid |
| wk_req_ready | input | 1 | Walker accepts request |
| wk_req_vaddr | output | 32 | Request virtual address |
| wk_req_op | output | 3 | Request operation selector |
| wk_req_user | output | 1 | Request is unprivileged |
| wk_rsp_valid | input | 1 | Walker response valid |
| wk_rsp_ready | output | 1 | Unit accepts response |
| wk_rsp_fault | input | 1 | Response is a fault |
| wk_rsp_status | input | 6 | Fault status code |
| wk_rsp_pfn | input | 28 | Physical address bits [39:12] |
| wk_rsp_super | input | 1 | Mapping is a 16 MB supersection |
| par_lo | output | 32 | Result register bits [31:0] |
| par_hi | output | 32 | Result register bits [63:32] |

## Verification
The hardest situation to reach is a second command write that lands while a query is still outstanding. It has to arrive both while the request is stalled by the walker and while the unit waits for the response. The bench's walker model holds `wk_req_ready` and `wk_rsp_valid` low for several programmed cycles and fires a conflicting command write inside each window. It then checks that the request payload, the absence of a second request and the stale result all hold. Near-exhaustive sweeps cover every status code in both layouts and every operation selector.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xlat_st_e;

  localparam int PAR_W          = 64;
  localparam int SHORT_W        = 32;
  localparam int PG_LSB         = 12;
  localparam int SUPER_LSB      = 24;
  localparam int LONG_MARK_BIT  = 11;
  localparam int SUPER_FLAG_BIT = 1;
  localparam int SHORT_FS_W     = 4;
endpackage

// File: rtl/xlat_req_ctrl.sv
module xlat_req_ctrl
  import xlat_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int OP_W     = 3,
  parameter int USER_BIT = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [OP_W-1:0] cmd_op,
  input  logic [VA_W-1:0] cmd_vaddr,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [VA_W-1:0] req_vaddr,
  output logic [OP_W-1:0] req_op,
  output logic            req_user,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  output logic            busy,
  output logic            rsp_fire
);
  xlat_st_e        state_q, state_d;
  logic [VA_W-1:0] vaddr_q;
  logic [OP_W-1:0] op_q;
  logic            cmd_take;
  logic            req_fire;

  assign cmd_take  = cmd_wr && (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
  assign rsp_ready = (state_q == ST_WAIT);
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign busy      = (state_q != ST_IDLE);
  assign req_vaddr = vaddr_q;
  assign req_op    = op_q;
  assign req_user  = op_q[USER_BIT];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (cmd_take) state_d = ST_REQ;
      ST_REQ:  if (req_fire) state_d = ST_WAIT;
      ST_WAIT: if (rsp_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_take) begin
        vaddr_q <= cmd_vaddr;
        op_q    <= cmd_op;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_vaddr) && $stable(req_op)); // R1
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid); // R1
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready)); // R3
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> busy); // R3
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> !busy); // R3
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy |=> $stable(req_vaddr) && $stable(req_op)); // R4
endmodule

// File: rtl/xlat_result_fmt.sv
module xlat_result_fmt
  import xlat_pkg::*;
#(
  parameter int PA_W = 40,
  parameter int FS_W = 6
) (
  input  logic                   long_mode,
  input  logic                   fault,
  input  logic [FS_W-1:0]        status,
  input  logic [PA_W-1:PG_LSB]   pfn,
  input  logic                   super_map,
  output logic [PAR_W-1:0]       par_d
);
  localparam int PFN_W = PA_W - PG_LSB;

  function automatic logic [PAR_W-1:0] pack_long(
    input logic fl, input logic [FS_W-1:0] st, input logic [PFN_W-1:0] fr);
    logic [PAR_W-1:0] r;
    r = '0;
    r[LONG_MARK_BIT] = 1'b1;
    if (fl) begin
      r[0]      = 1'b1;
      r[FS_W:1] = st;
    end else begin
      r[PA_W-1:PG_LSB] = fr;
    end
    return r;
  endfunction

  function automatic logic [PAR_W-1:0] pack_short(
    input logic fl, input logic [FS_W-1:0] st, input logic [PFN_W-1:0] fr,
    input logic sup);
    logic [PAR_W-1:0] r;
    r = '0;
    if (fl) begin
      r[0]            = 1'b1;
      r[SHORT_FS_W:1] = st[SHORT_FS_W-1:0];
    end else if (sup) begin
      r[SHORT_W-1:SUPER_LSB] = fr[SHORT_W-1-PG_LSB:SUPER_LSB-PG_LSB];
      r[SUPER_FLAG_BIT]      = 1'b1;
    end else begin
      r[SHORT_W-1:PG_LSB] = fr[SHORT_W-1-PG_LSB:0];
    end
    return r;
  endfunction

  always_comb begin
    if (long_mode) par_d = pack_long(fault, status, pfn);
    else           par_d = pack_short(fault, status, pfn, super_map);
  end
endmodule

// File: rtl/xlat_par_unit.sv
module xlat_par_unit
  import xlat_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 40,
  parameter int OP_W     = 3,
  parameter int FS_W     = 6,
  parameter int USER_BIT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    long_mode,
  input  logic                    cmd_wr,
  input  logic [OP_W-1:0]         cmd_op,
  input  logic [VA_W-1:0]         cmd_vaddr,
  output logic                    busy,
  output logic                    wk_req_valid,
  input  logic                    wk_req_ready,
  output logic [VA_W-1:0]         wk_req_vaddr,
  output logic [OP_W-1:0]         wk_req_op,
  output logic                    wk_req_user,
  input  logic                    wk_rsp_valid,
  output logic                    wk_rsp_ready,
  input  logic                    wk_rsp_fault,
  input  logic [FS_W-1:0]         wk_rsp_status,
  input  logic [PA_W-PG_LSB-1:0]  wk_rsp_pfn,
  input  logic                    wk_rsp_super,
  output logic [SHORT_W-1:0]      par_lo,
  output logic [PAR_W-SHORT_W-1:0] par_hi
);
  logic             rsp_fire;
  logic [PAR_W-1:0] par_d;
  logic [PAR_W-1:0] par_q;

  xlat_req_ctrl #(.VA_W(VA_W), .OP_W(OP_W), .USER_BIT(USER_BIT)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_op    (cmd_op),
    .cmd_vaddr (cmd_vaddr),
    .req_valid (wk_req_valid),
    .req_ready (wk_req_ready),
    .req_vaddr (wk_req_vaddr),
    .req_op    (wk_req_op),
    .req_user  (wk_req_user),
    .rsp_valid (wk_rsp_valid),
    .rsp_ready (wk_rsp_ready),
    .busy      (busy),
    .rsp_fire  (rsp_fire)
  );

  xlat_result_fmt #(.PA_W(PA_W), .FS_W(FS_W)) fmt_i (
    .long_mode (long_mode),
    .fault     (wk_rsp_fault),
    .status    (wk_rsp_status),
    .pfn       (wk_rsp_pfn),
    .super_map (wk_rsp_super),
    .par_d     (par_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        par_q <= '0;
    else if (rsp_fire) par_q <= par_d;
  end

  assign par_lo = par_q[SHORT_W-1:0];
  assign par_hi = par_q[PAR_W-1:SHORT_W];

  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fire |=> $stable(par_q)); // R5
  AST_LONG_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && long_mode |=> par_q[LONG_MARK_BIT]); // R6
  AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && wk_rsp_fault |=> par_q[0]); // R7
  AST_SHORT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && !long_mode |=> (par_hi == '0)); // R8
  AST_SHORT_FAULT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && !long_mode && wk_rsp_fault |=> (par_lo[SHORT_W-1:SHORT_FS_W+1] == '0)); // R10
endmodule

// File: tb/xlat_par_unit_tb_top.sv
module xlat_par_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        long_mode = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_vaddr = '0;
  logic        busy;
  logic        wk_req_valid;
  logic        wk_req_ready = 1'b0;
  logic [31:0] wk_req_vaddr;
  logic [2:0]  wk_req_op;
  logic        wk_req_user;
  logic        wk_rsp_valid = 1'b0;
  logic        wk_rsp_ready;
  logic        wk_rsp_fault = 1'b0;
  logic [5:0]  wk_rsp_status = '0;
  logic [27:0] wk_rsp_pfn = '0;
  logic        wk_rsp_super = 1'b0;
  logic [31:0] par_lo;
  logic [31:0] par_hi;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  xlat_par_unit dut_i (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_vaddr(cmd_vaddr),
    .busy(busy),
    .wk_req_valid(wk_req_valid), .wk_req_ready(wk_req_ready),
    .wk_req_vaddr(wk_req_vaddr), .wk_req_op(wk_req_op), .wk_req_user(wk_req_user),
    .wk_rsp_valid(wk_rsp_valid), .wk_rsp_ready(wk_rsp_ready),
    .wk_rsp_fault(wk_rsp_fault), .wk_rsp_status(wk_rsp_status),
    .wk_rsp_pfn(wk_rsp_pfn), .wk_rsp_super(wk_rsp_super),
    .par_lo(par_lo), .par_hi(par_hi)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic longint unsigned par_now();
    return (longint'(par_hi) << 32) | longint'(par_lo);
  endfunction

  function automatic longint unsigned expect_par(input bit md, input bit fl,
      input int st, input longint unsigned pfn, input bit sup);
    longint unsigned pa;
    pa = pfn * 4096;
    if (md) begin
      if (fl) return 2048 + st * 2 + 1;
      return pa + 2048;
    end
    if (fl) return (st % 16) * 2 + 1;
    if (sup) return ((pa % 64'h1_0000_0000) / 64'h100_0000) * 64'h100_0000 + 2;
    return pa % 64'h1_0000_0000;
  endfunction

  task automatic xact(input bit md, input int op, input longint unsigned va,
      input bit fl, input int st, input longint unsigned pfn, input bit sup,
      input int rl, input int wl, input bit poke);
    longint unsigned prev;
    string tag;
    long_mode = md;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_op = 3'(op); cmd_vaddr = 32'(va);
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R3 busy after accept", busy, 1);
    chk("R1 request valid", wk_req_valid, 1);
    chk("R1 request vaddr", wk_req_vaddr, va);
    chk("R1 request op", wk_req_op, op);
    chk("R2 user flag", wk_req_user, (op / 2) % 2);
    chk("R3 rsp_ready low before request handshake", wk_rsp_ready, 0);
    prev = par_now();
    for (int i = 0; i < rl; i++) begin
      if (poke && i == 0) begin
        cmd_wr = 1'b1; cmd_vaddr = ~32'(va); cmd_op = ~3'(op);
      end
      @(negedge clk);
      cmd_wr = 1'b0;
      chk("R1 request held", wk_req_valid, 1);
      chk("R4 payload vaddr unchanged", wk_req_vaddr, va);
      chk("R4 payload op unchanged", wk_req_op, op);
    end
    wk_req_ready = 1'b1;
    @(negedge clk);
    wk_req_ready = 1'b0;
    chk("R1 request dropped after handshake", wk_req_valid, 0);
    chk("R3 rsp_ready in wait", wk_rsp_ready, 1);
    for (int i = 0; i < wl; i++) begin
      if (poke) begin
        cmd_wr = 1'b1; cmd_vaddr = 32'(va) ^ 32'h5a5a_0000;
      end
      @(negedge clk);
      cmd_wr = 1'b0;
      chk("R4 no second request", wk_req_valid, 0);
      chk("R5 result holds while waiting", par_now(), prev);
      chk("R3 busy while waiting", busy, 1);
    end
    wk_rsp_valid = 1'b1; wk_rsp_fault = fl; wk_rsp_status = 6'(st);
    wk_rsp_pfn = 28'(pfn); wk_rsp_super = sup;
    @(negedge clk);
    wk_rsp_valid = 1'b0;
    if (md && fl)       tag = "R7 long fault";
    else if (md)        tag = "R6 long success";
    else if (fl)        tag = "R10 short fault";
    else if (sup)       tag = "R9 short supersection";
    else                tag = "R8 short page";
    chk(tag, par_now(), expect_par(md, fl, st, pfn, sup));
    chk("R3 busy cleared", busy, 0);
    chk("R3 rsp_ready cleared", wk_rsp_ready, 0);
    if (poke) begin
      @(negedge clk);
      chk("R4 no late request", wk_req_valid, 0);
      chk("R5 result holds when idle", par_now(), expect_par(md, fl, st, pfn, sup));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset result", par_now(), 0);
    chk("R3 reset busy", busy, 0);
    chk("R1 reset no request", wk_req_valid, 0);
    chk("R3 reset rsp_ready", wk_rsp_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 result zero after reset", par_now(), 0);

    for (int md = 0; md < 2; md++)
      for (int op = 0; op < 8; op++)
        xact(md[0], op, 64'h1000_0000 * op + 64'h0123_4567 + md,
             1'b0, 0, (64'h0ABC_DEF + op * 64'h1357_9B1) % 64'h1000_0000,
             1'b0, op % 3, op % 4, 1'b0);

    for (int md = 0; md < 2; md++)
      for (int st = 0; st < 64; st++)
        xact(md[0], st % 8, 64'hF000_0000 + st, 1'b1, st,
             64'hFFF_FFFF - st, st % 2 == 1, 0, st % 2, 1'b0);

    for (int k = 0; k < 6; k++) begin
      xact(1'b0, 2, 64'h8000_0000 + k, 1'b0, 0,
           (64'h0FF_FFFF * k + 64'h5A5_A5A5) % 64'h1000_0000, 1'b1, k % 2, 1, 1'b0);
      xact(1'b1, 0, 64'h4000_0000 + k, 1'b0, 0,
           (64'h0FF_FFFF * k + 64'h5A5_A5A5) % 64'h1000_0000, 1'b1, 1, 0, 1'b0);
    end
    xact(1'b0, 0, 0, 1'b0, 0, 64'hFFF_FFFF, 1'b0, 0, 0, 1'b0);
    xact(1'b1, 0, 0, 1'b0, 0, 64'hFFF_FFFF, 1'b0, 0, 0, 1'b0);
    xact(1'b0, 0, 0, 1'b0, 0, 0, 1'b1, 0, 0, 1'b0);

    for (int k = 0; k < 4; k++)
      xact(k[0], k * 2, 64'h1357_2468 * (k + 1), k[1], 63 - k,
           64'h0246_8AC + k, k[1], 2 + k, 3, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule